// File: doc/BRIEF.md
# Go-Back-N Retransmission Sender

This block is the transmit half of a link-level reliable delivery scheme over a slotted switch fabric. Each packet descriptor it accepts is sent at once and is also kept in a first-in, first-out retransmission buffer. With it the buffer holds the slot number in which the packet went out and a retry budget. The receiving end returns one positive acknowledgment per packet. An acknowledgment that names the oldest outstanding sequence number retires that entry. No negative acknowledgments exist, so loss is inferred only from elapsed time.

A free-running slot counter drives the timer. When the oldest entry has waited for the fixed round-trip time without an acknowledgment, the sender assumes it was lost. It then resends every outstanding entry, oldest first, one per cycle, and restarts each entry's timer. Each resend uses up one unit of the entry's retry budget. When the oldest entry times out with no budget left, it is discarded and reported on a one-cycle drop output, so a broken link cannot stall the sender for ever. The receiver therefore only ever sees packets in order and needs no reordering store.

Top module: `gbn_retx_sender`

## Requirements
- R1: During and right after reset, `in_ready` is 1, `tx_valid` is 0 and `drop_valid` is 0.
- R2: A descriptor accepted on a clock edge (`in_valid` and `in_ready` both 1) appears on `tx_desc` with `tx_valid`=1 and `tx_retx`=0 in the following cycle. Sequence numbers start at 0 after reset and rise by one per accepted descriptor, modulo 2*DEPTH.
- R3: `in_ready` is 0 whenever DEPTH entries are outstanding.
- R4: An acknowledgment (`ack_valid`=1) whose `ack_seq` equals the oldest outstanding sequence number retires that entry. An acknowledgment with any other number, including a repeat of an already retired one, changes nothing.
- R5: The age of the oldest entry is `slot_now` minus the slot it was last sent in, modulo 2^TS_W. When this age reaches RTT and the entry still has retry budget, all outstanding entries are resent, oldest first, on consecutive cycles with `tx_retx`=1. The first resend appears on the transmit output RTT+1 slots after the previous transmission of that oldest entry.
- R6: A resend restarts the entry's timer, so a second resend of the same oldest entry follows the first one RTT+1 slots later.
- R7: `in_ready` is 0 while a resend burst runs and while the oldest entry is timed out. A descriptor offered during a burst is transmitted only after the last resend of that burst.
- R8: Every entry starts with a retry budget of TTL_INIT, which each resend lowers by one. An entry is therefore resent at most TTL_INIT times. When the oldest entry times out with a budget of zero, it is discarded and retired, with no resend, RTT slots after its last transmission.
- R9: Each discard raises `drop_valid` for exactly one cycle in the cycle after the decision, with `drop_seq` holding the discarded sequence number. A drop cycle never carries `tx_valid`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A new packet descriptor is offered |
| in_ready | output | 1 | The sender takes the offered descriptor on this edge |
| in_desc | input | DESC_W | Packet descriptor |
| slot_now | input | TS_W | Free-running slot counter |
| ack_valid | input | 1 | A positive acknowledgment is present |
| ack_seq | input | log2(DEPTH)+1 | Sequence number being acknowledged |
| tx_valid | output | 1 | A packet is transmitted this cycle |
| tx_retx | output | 1 | 1 for a resend, 0 for a first transmission |
| tx_seq | output | log2(DEPTH)+1 | Sequence number of the transmitted packet |
| tx_desc | output | DESC_W | Descriptor of the transmitted packet |
| drop_valid | output | 1 | One-cycle pulse: a packet was abandoned |
| drop_seq | output | log2(DEPTH)+1 | Sequence number of the abandoned packet |

## Verification
The sender is tried with three acknowledgment patterns, each separating a different fault. First, acknowledgments arrive in order for every outstanding count from one to DEPTH, with the sequence number wrapping past 2*DEPTH. Any stray resend here shows that retiring or sequence numbering is wrong. Second, stale and repeated acknowledgments arrive against a full buffer. The size and starting point of the next resend burst show whether such an acknowledgment wrongly retired an entry. Third, acknowledgments stop completely. The spacing of the resend bursts, the number of resends for each packet and the order and timing of the drop reports then pin down the timer restart, the retry budget and the discard path to the exact slot.

// File: rtl/gbn_pkg.sv
// Package gbn_pkg
// Types shared by the go-back-N sender and its submodules.
// Assumes nothing beyond IEEE 1800-2017 packages.
package gbn_pkg;

    // Resend controller state: idle, or stepping through the buffer
    typedef enum logic [0:0] {
        BURST_IDLE = 1'b0,
        BURST_RUN  = 1'b1
    } burst_state_t;

endpackage : gbn_pkg

// File: rtl/gbn_retx_store.sv
// Module gbn_retx_store
// Circular retransmission buffer. Each entry holds a descriptor, the slot
// it was last sent in and its remaining retry budget. The read and write
// pointers are one bit wider than the index, so each pointer value is also
// the sequence number of the entry it points at (modulo 2*DEPTH).
// Assumes: DEPTH is a power of two and at least 2. push is never raised
// when full, pop never when empty. push and resend never hit the same
// entry in one cycle.
module gbn_retx_store #(
    parameter int DEPTH    = 4,
    parameter int DESC_W   = 8,
    parameter int TS_W     = 8,
    parameter int TTL_W    = 2,
    parameter int TTL_INIT = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic [DESC_W-1:0]        push_desc,
    input  logic [TS_W-1:0]          push_ts,
    input  logic                     pop,
    input  logic                     resend,
    input  logic [$clog2(DEPTH):0]   resend_seq,
    input  logic [TS_W-1:0]          resend_ts,
    output logic                     full,
    output logic                     empty,
    output logic [$clog2(DEPTH):0]   head_seq,
    output logic [$clog2(DEPTH):0]   tail_seq,
    output logic [DESC_W-1:0]        head_desc,
    output logic [TS_W-1:0]          head_ts,
    output logic [TTL_W-1:0]         head_ttl,
    output logic [DESC_W-1:0]        resend_desc,
    output logic [TTL_W-1:0]         resend_ttl
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int SEQ_W = IDX_W + 1;
    localparam logic [SEQ_W-1:0]  DEPTH_SEQ = SEQ_W'(DEPTH);
    localparam logic [TTL_W-1:0]  TTL_START = TTL_W'(TTL_INIT);

    logic [DESC_W-1:0] desc_q [DEPTH];
    logic [TS_W-1:0]   ts_q   [DEPTH];
    logic [TTL_W-1:0]  ttl_q  [DEPTH];
    logic [SEQ_W-1:0]  rd_ptr;
    logic [SEQ_W-1:0]  wr_ptr;
    logic [IDX_W-1:0]  rd_idx;
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rs_idx;
    logic [SEQ_W-1:0]  fill;

    assign rd_idx = rd_ptr[IDX_W-1:0];
    assign wr_idx = wr_ptr[IDX_W-1:0];
    assign rs_idx = resend_seq[IDX_W-1:0];
    assign fill   = wr_ptr - rd_ptr;

    // Occupancy flags derived from the pointer distance
    always_comb begin
        full  = (fill == DEPTH_SEQ);
        empty = (fill == '0);
    end

    // Read ports: the oldest entry and the entry being resent
    always_comb begin
        head_seq    = rd_ptr;
        tail_seq    = wr_ptr;
        head_desc   = desc_q[rd_idx];
        head_ts     = ts_q[rd_idx];
        head_ttl    = ttl_q[rd_idx];
        resend_desc = desc_q[rs_idx];
        resend_ttl  = ttl_q[rs_idx];
    end

    // Pointer update on push and on retirement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Entry contents: a push fills an entry, a resend restamps it and spends budget
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                desc_q[i] <= '0;
                ts_q[i]   <= '0;
                ttl_q[i]  <= '0;
            end
        end else begin
            if (push) begin
                desc_q[wr_idx] <= push_desc;
                ts_q[wr_idx]   <= push_ts;
                ttl_q[wr_idx]  <= TTL_START;
            end
            if (resend) begin
                ts_q[rs_idx] <= resend_ts;
                if (resend_ttl != '0) ttl_q[rs_idx] <= resend_ttl - 1'b1;
            end
        end
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    // R8
    ttl_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resend |-> (resend_ttl != '0));

endmodule : gbn_retx_store

// File: rtl/gbn_age_check.sv
// Module gbn_age_check
// Flags the oldest entry as timed out once the slot distance since its last
// transmission reaches the round-trip time. The difference is taken modulo
// 2^TS_W.
// Assumes: RTT plus DEPTH is well below 2^TS_W. The check then runs often
// enough that an age never wraps before it is seen.
module gbn_age_check #(
    parameter int TS_W = 8,
    parameter int RTT  = 40
) (
    input  logic            valid,
    input  logic [TS_W-1:0] now,
    input  logic [TS_W-1:0] stamp,
    output logic            aged
);

    localparam logic [TS_W-1:0] RTT_TS = TS_W'(RTT);

    logic [TS_W-1:0] age;

    // Modular age and threshold comparison
    always_comb begin
        age  = now - stamp;
        aged = valid && (age >= RTT_TS);
    end

endmodule : gbn_age_check

// File: rtl/gbn_burst_ctrl.sv
// Module gbn_burst_ctrl
// Steps a resend pointer from the oldest entry to the newest, one entry per
// cycle, after a timeout. The burst ends on the cycle that resends the
// newest entry.
// Assumes: start is raised only while idle with a non-empty buffer, and no
// push happens while active.
module gbn_burst_ctrl #(
    parameter int SEQ_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SEQ_W-1:0] head_seq,
    input  logic [SEQ_W-1:0] tail_seq,
    output logic             active,
    output logic [SEQ_W-1:0] resend_seq
);

    import gbn_pkg::*;

    burst_state_t     state_q;
    logic [SEQ_W-1:0] bptr_q;
    logic [SEQ_W-1:0] bptr_nxt;

    assign bptr_nxt   = bptr_q + 1'b1;
    assign active     = (state_q == BURST_RUN);
    assign resend_seq = bptr_q;

    // Burst state and resend pointer sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BURST_IDLE;
            bptr_q  <= '0;
        end else begin
            case (state_q)
                BURST_IDLE: begin
                    if (start) begin
                        state_q <= BURST_RUN;
                        bptr_q  <= head_seq;
                    end
                end
                BURST_RUN: begin
                    bptr_q <= bptr_nxt;
                    if (bptr_nxt == tail_seq) state_q <= BURST_IDLE;
                end
                default: state_q <= BURST_IDLE;
            endcase
        end
    end

    // R5
    burst_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (SEQ_W'(bptr_q - head_seq) < SEQ_W'(tail_seq - head_seq)));

endmodule : gbn_burst_ctrl

// File: rtl/gbn_retx_sender.sv
// Module gbn_retx_sender
// Go-back-N sender. New descriptors are sent and buffered. In-order positive
// acknowledgments retire the oldest entry. A timeout of the oldest entry
// resends the whole buffer, or discards that entry once its retry budget is
// spent.
// Assumes: slot_now advances by at most one per cycle. RTT + DEPTH is well
// below 2^TS_W. DEPTH is a power of two and at least 2.
module gbn_retx_sender #(
    parameter int DEPTH    = 4,
    parameter int DESC_W   = 8,
    parameter int TS_W     = 8,
    parameter int RTT      = 40,
    parameter int TTL_INIT = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [DESC_W-1:0]       in_desc,
    input  logic [TS_W-1:0]         slot_now,
    input  logic                    ack_valid,
    input  logic [$clog2(DEPTH):0]  ack_seq,
    output logic                    tx_valid,
    output logic                    tx_retx,
    output logic [$clog2(DEPTH):0]  tx_seq,
    output logic [DESC_W-1:0]       tx_desc,
    output logic                    drop_valid,
    output logic [$clog2(DEPTH):0]  drop_seq
);

    localparam int SEQ_W = $clog2(DEPTH) + 1;
    localparam int TTL_W = $clog2(TTL_INIT + 1);

    logic              full;
    logic              empty;
    logic [SEQ_W-1:0]  head_seq;
    logic [SEQ_W-1:0]  tail_seq;
    logic [DESC_W-1:0] head_desc;
    logic [TS_W-1:0]   head_ts;
    logic [TTL_W-1:0]  head_ttl;
    logic [DESC_W-1:0] resend_desc;
    logic [TTL_W-1:0]  resend_ttl;
    logic [SEQ_W-1:0]  resend_seq;
    logic              burst_active;
    logic              aged;
    logic              ack_hit;
    logic              timeout_go;
    logic              drop_go;
    logic              burst_go;
    logic              push;
    logic              pop;

    // Decisions taken on the oldest entry each cycle
    always_comb begin
        ack_hit    = ack_valid && !empty && (ack_seq == head_seq);
        timeout_go = aged && !burst_active && !ack_hit;
        drop_go    = timeout_go && (head_ttl == '0);
        burst_go   = timeout_go && (head_ttl != '0);
        pop        = ack_hit || drop_go;
        in_ready   = !full && !burst_active && !aged;
        push       = in_valid && in_ready;
    end

    gbn_retx_store #(
        .DEPTH    (DEPTH),
        .DESC_W   (DESC_W),
        .TS_W     (TS_W),
        .TTL_W    (TTL_W),
        .TTL_INIT (TTL_INIT)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (push),
        .push_desc   (in_desc),
        .push_ts     (slot_now),
        .pop         (pop),
        .resend      (burst_active),
        .resend_seq  (resend_seq),
        .resend_ts   (slot_now),
        .full        (full),
        .empty       (empty),
        .head_seq    (head_seq),
        .tail_seq    (tail_seq),
        .head_desc   (head_desc),
        .head_ts     (head_ts),
        .head_ttl    (head_ttl),
        .resend_desc (resend_desc),
        .resend_ttl  (resend_ttl)
    );

    gbn_age_check #(
        .TS_W (TS_W),
        .RTT  (RTT)
    ) u_age (
        .valid (!empty),
        .now   (slot_now),
        .stamp (head_ts),
        .aged  (aged)
    );

    gbn_burst_ctrl #(
        .SEQ_W (SEQ_W)
    ) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (burst_go),
        .head_seq   (head_seq),
        .tail_seq   (tail_seq),
        .active     (burst_active),
        .resend_seq (resend_seq)
    );

    // Registered transmit output: a resend or a first transmission
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_retx  <= 1'b0;
            tx_seq   <= '0;
            tx_desc  <= '0;
        end else begin
            tx_valid <= push || burst_active;
            if (burst_active) begin
                tx_retx <= 1'b1;
                tx_seq  <= resend_seq;
                tx_desc <= resend_desc;
            end else if (push) begin
                tx_retx <= 1'b0;
                tx_seq  <= tail_seq;
                tx_desc <= in_desc;
            end
        end
    end

    // Registered one-cycle drop report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_valid <= 1'b0;
            drop_seq   <= '0;
        end else begin
            drop_valid <= drop_go;
            if (drop_go) drop_seq <= head_seq;
        end
    end

    // R9
    drop_tx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_valid |-> !tx_valid);

    // R4
    ack_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit |=> (head_seq == SEQ_W'($past(head_seq) + 1'b1)));

    // R8
    drop_only_spent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_valid |-> ($past(head_ttl) == '0));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !$past(rst_n) |-> (!tx_valid && !drop_valid));

endmodule : gbn_retx_sender

// File: tb/test_gbn_retx_sender.sv
// Bench for gbn_retx_sender: a small configuration (DEPTH 4, RTT 40,
// retry budget 3). Expected slots and sequence numbers are worked out
// arithmetically from the requirements.
module test_gbn_retx_sender;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int DESC_W     = 8;
    localparam int TS_W       = 8;
    localparam int RTT        = 40;
    localparam int TTL_INIT   = 3;
    localparam int SEQ_W      = $clog2(DEPTH) + 1;
    localparam int SEQ_MOD    = 2 * DEPTH;
    localparam int LOG_N      = 256;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [DESC_W-1:0] in_desc = '0;
    logic [TS_W-1:0]   slot_now;
    logic              ack_valid = 1'b0;
    logic [SEQ_W-1:0]  ack_seq = '0;
    logic              tx_valid;
    logic              tx_retx;
    logic [SEQ_W-1:0]  tx_seq;
    logic [DESC_W-1:0] tx_desc;
    logic              drop_valid;
    logic [SEQ_W-1:0]  drop_seq;

    int slot_cnt = 0;
    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    int n_tx = 0;
    int tx_seq_log  [LOG_N];
    int tx_retx_log [LOG_N];
    int tx_desc_log [LOG_N];
    int tx_slot_log [LOG_N];
    int n_drop = 0;
    int drop_seq_log  [32];
    int drop_slot_log [32];

    gbn_retx_sender #(
        .DEPTH    (DEPTH),
        .DESC_W   (DESC_W),
        .TS_W     (TS_W),
        .RTT      (RTT),
        .TTL_INIT (TTL_INIT)
    ) i_gbn_retx_sender (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_desc    (in_desc),
        .slot_now   (slot_now),
        .ack_valid  (ack_valid),
        .ack_seq    (ack_seq),
        .tx_valid   (tx_valid),
        .tx_retx    (tx_retx),
        .tx_seq     (tx_seq),
        .tx_desc    (tx_desc),
        .drop_valid (drop_valid),
        .drop_seq   (drop_seq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Free-running slot counter, one slot per clock
    always @(posedge clk) slot_cnt <= slot_cnt + 1;
    assign slot_now = slot_cnt[TS_W-1:0];

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && tx_valid && n_tx < LOG_N) begin
            tx_seq_log[n_tx]  = int'(tx_seq);
            tx_retx_log[n_tx] = int'(tx_retx);
            tx_desc_log[n_tx] = int'(tx_desc);
            tx_slot_log[n_tx] = slot_cnt;
            n_tx++;
        end
        if (rst_n && drop_valid && n_drop < 32) begin
            drop_seq_log[n_drop]  = int'(drop_seq);
            drop_slot_log[n_drop] = slot_cnt;
            n_drop++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [DESC_W-1:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_desc  = d;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic ack(input int s);
        @(negedge clk);
        ack_valid = 1'b1;
        ack_seq   = SEQ_W'(s);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    // Index of the k-th resend (k from 1) of a sequence number, or -1
    function automatic int find_retx(input int s, input int k);
        int hits = 0;
        for (int i = 0; i < n_tx; i++) begin
            if (tx_seq_log[i] == s && tx_retx_log[i] == 1) begin
                hits++;
                if (hits == k) return i;
            end
        end
        return -1;
    endfunction

    function automatic int count_retx(input int s);
        int hits = 0;
        for (int i = 0; i < n_tx; i++)
            if (tx_seq_log[i] == s && tx_retx_log[i] == 1) hits++;
        return hits;
    endfunction

    // Watchdog: a hung run counts as a failure
    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int base;
        int exp_seq;
        int idx;
        int idx2;
        int guard;

        // ---- R1: reset state ----
        rst_n = 1'b0;
        wait_cycles(3);
        check(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
        check(tx_valid == 1'b0, "R1", "tx_valid in reset", int'(tx_valid), 0);
        check(drop_valid == 1'b0, "R1", "drop_valid in reset", int'(drop_valid), 0);
        rst_n = 1'b1;
        wait_cycles(1);
        check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

        // ---- Scenario A: fill, stale and repeated ACKs, then silence ----
        for (int i = 0; i < DEPTH; i++) send(DESC_W'(8'hA0 + i));
        wait_cycles(1);
        check(n_tx == DEPTH, "R2", "first transmissions", n_tx, DEPTH);
        for (int i = 0; i < DEPTH; i++) begin
            check(tx_seq_log[i] == i, "R2", "sequence number", tx_seq_log[i], i);
            check(tx_retx_log[i] == 0, "R2", "first send flag", tx_retx_log[i], 0);
            check(tx_desc_log[i] == 8'hA0 + i, "R2", "descriptor", tx_desc_log[i], 8'hA0 + i);
        end
        check(in_ready == 1'b0, "R3", "ready when full", int'(in_ready), 0);

        ack(2);
        check(in_ready == 1'b0, "R4", "out-of-order ACK ignored", int'(in_ready), 0);
        ack(0);
        check(in_ready == 1'b1, "R4", "head ACK retires", int'(in_ready), 1);
        ack(0);

        base  = n_tx;
        guard = 0;
        while (n_tx == base && guard < 400) begin
            @(negedge clk);
            guard++;
        end
        send(8'hA4);

        guard = 0;
        while (n_drop < 4 && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        wait_cycles(1);

        // R4 (repeated ACK) and R5: first burst resends 1,2,3 back to back
        for (int i = 0; i < 3; i++) begin
            check(tx_seq_log[base + i] == i + 1, "R5", "burst order", tx_seq_log[base + i], i + 1);
            check(tx_retx_log[base + i] == 1, "R5", "burst flag", tx_retx_log[base + i], 1);
            check(tx_desc_log[base + i] == 8'hA1 + i, "R5", "burst descriptor",
                  tx_desc_log[base + i], 8'hA1 + i);
            check(tx_slot_log[base + i] == tx_slot_log[base] + i, "R5", "burst spacing",
                  tx_slot_log[base + i], tx_slot_log[base] + i);
        end
        check(tx_slot_log[base] - tx_slot_log[1] == RTT + 1, "R5", "timeout delay",
              tx_slot_log[base] - tx_slot_log[1], RTT + 1);

        // R7: new packet held back until the burst ends
        check(tx_seq_log[base + 3] == 4 && tx_retx_log[base + 3] == 0, "R7",
              "new packet after burst", tx_seq_log[base + 3], 4);

        // R6: timer restarted by the resend
        idx  = find_retx(1, 1);
        idx2 = find_retx(1, 2);
        check(idx2 >= 0 && tx_slot_log[idx2] - tx_slot_log[idx] == RTT + 1, "R6",
              "second resend spacing", (idx2 >= 0) ? tx_slot_log[idx2] - tx_slot_log[idx] : -1, RTT + 1);

        // R8: each packet resent exactly TTL_INIT times, then discarded
        for (int s = 1; s <= 4; s++)
            check(count_retx(s) == TTL_INIT, "R8", "resends per packet", count_retx(s), TTL_INIT);
        check(n_tx == DEPTH + 1 + 4 * TTL_INIT, "R8", "total transmissions",
              n_tx, DEPTH + 1 + 4 * TTL_INIT);
        idx = find_retx(1, TTL_INIT);
        check(idx >= 0 && drop_slot_log[0] - tx_slot_log[idx] == RTT, "R8", "drop delay",
              (idx >= 0) ? drop_slot_log[0] - tx_slot_log[idx] : -1, RTT);

        // R9: drop reports in order, one cycle each
        check(n_drop == 4, "R9", "drop count", n_drop, 4);
        for (int i = 0; i < 4; i++)
            check(drop_seq_log[i] == i + 1, "R9", "drop sequence", drop_seq_log[i], i + 1);
        for (int i = 1; i < 3; i++)
            check(drop_slot_log[i] == drop_slot_log[0] + i, "R9", "drop pulse spacing",
                  drop_slot_log[i], drop_slot_log[0] + i);

        base = n_tx;
        wait_cycles(2 * RTT);
        check(n_tx == base, "R8", "quiet after drops", n_tx, base);
        check(n_drop == 4, "R9", "no extra drop", n_drop, 4);
        check(in_ready == 1'b1, "R8", "buffer empty after drops", int'(in_ready), 1);

        // ---- Scenario B: in-order ACK sweep over 1..DEPTH outstanding ----
        exp_seq = 5;
        for (int n = 1; n <= DEPTH; n++) begin
            base = n_tx;
            for (int k = 0; k < n; k++) send(DESC_W'(16 * n + k));
            wait_cycles(1);
            for (int k = 0; k < n; k++) begin
                check(tx_seq_log[base + k] == (exp_seq + k) % SEQ_MOD, "R2", "wrapped sequence",
                      tx_seq_log[base + k], (exp_seq + k) % SEQ_MOD);
                check(tx_desc_log[base + k] == 16 * n + k, "R2", "sweep descriptor",
                      tx_desc_log[base + k], 16 * n + k);
            end
            if (n == DEPTH)
                check(in_ready == 1'b0, "R3", "ready when full (sweep)", int'(in_ready), 0);
            for (int k = 0; k < n; k++) ack((exp_seq + k) % SEQ_MOD);
            check(in_ready == 1'b1, "R4", "all retired", int'(in_ready), 1);
            exp_seq += n;
            wait_cycles(RTT + 8);
            check(n_tx == base + n, "R4", "no resend after ACKs", n_tx, base + n);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule : test_gbn_retx_sender